// File: doc/BRIEF.md
# Masked-Access GPIO Port on APB

This block is an eight-pin general-purpose I/O port behind an APB slave. Software sets each pin's direction and drives its output value. Software can also hand a pin to an on-chip hardware source, which then supplies both the pin's output value and its output enable. Data accesses take their bit mask from the address. Word address bits 9..2 select which pins a read returns or a write changes, so one pin can be set or sampled without a read-modify-write sequence.

Each pin can raise an interrupt on a level, on one edge or on both edges. Pad inputs pass through a synchronizer before detection. Edge events latch in a raw status register until software writes a 1 to the matching clear bit. A per-pin enable masks the raw status, and the masked bits are ORed into a single interrupt line. Every transfer completes with no wait states and never reports an error.

Top module: `gpm_apb_gpio`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: A write in the data region (byte offsets 0x000..0x3FC) changes output bit N only when address bit N+2 is 1. All other output bits keep their value.
- R3: A read in the data region returns, for each bit N whose address bit N+2 is 1, the pin value: the output register bit for an output pin, or the synchronized pad input for an input pin. Bits with a 0 address mask bit read as 0.
- R4: While a pin's alternate select bit is 0, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output register bit.
- R5: While a pin's alternate select bit (offset 0x420) is 1, `pad_out` and `pad_oe` follow `hw_out` and `hw_oe` for that pin.
- R6: With sense bit 0 (edge) and both-edges bit 0, a pin latches raw status on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0.
- R7: With sense bit 0 and both-edges bit 1, either edge latches raw status.
- R8: With sense bit 1 (level), the raw bit follows the synchronized level without latching. It is 1 while the pin is high if polarity is 1, and while the pin is low if polarity is 0.
- R9: Writing 1 to a clear-register bit (offset 0x41C) clears that pin's latched edge status, and 0 bits leave status unchanged. The clear register reads as 0.
- R10: Masked status (0x418) equals raw status (0x414) AND enable (0x410), and `irq` is 1 exactly when masked status is nonzero.
- R11: Reads of unmapped offsets (above 0x420 and outside the data region) return 0. `pready` is 1 and `pslverr` is 0.
- R12: Direction (0x400), sense (0x404), both-edges (0x408), polarity (0x40C), enable (0x410) and alternate select (0x420) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready (always 1) |
| pslverr | output | 1 | Error response (always 0) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| hw_out | input | 8 | Alternate-function output values |
| hw_oe | input | 8 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The masked write is swept over all 256 address masks, each with a different data byte. This separates a mask that is applied from one that is inverted, shifted by one bit or ignored. Masked reads are swept over all 256 masks with a mixed direction setting and two pad patterns. This shows whether each bit comes from the output register or from the pad, and whether unmasked bits read as 0. The interrupt tests apply rising, falling and both-edge events, then switch to level sense. Comparing latched bits with level-following bits, and full clears with partial clears, separates the detection modes. The enable mask tells raw status apart from masked status.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

   // word offsets (byte offset >> 2) of the control registers
   localparam logic [9:0] WO_DIR   = 10'h100;
   localparam logic [9:0] WO_SENSE = 10'h101;
   localparam logic [9:0] WO_BOTH  = 10'h102;
   localparam logic [9:0] WO_POL   = 10'h103;
   localparam logic [9:0] WO_IE    = 10'h104;
   localparam logic [9:0] WO_RAW   = 10'h105;
   localparam logic [9:0] WO_MIS   = 10'h106;
   localparam logic [9:0] WO_CLR   = 10'h107;
   localparam logic [9:0] WO_ALT   = 10'h108;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_POL,
      SEL_IE, SEL_RAW, SEL_MIS, SEL_CLR, SEL_ALT
   } gpm_sel_e;

   function automatic gpm_sel_e gpm_decode(input logic [9:0] word);
      gpm_sel_e s;
      if (word[9:8] == 2'b00) s = SEL_DATA;
      else begin
         case (word)
            WO_DIR:   s = SEL_DIR;
            WO_SENSE: s = SEL_SENSE;
            WO_BOTH:  s = SEL_BOTH;
            WO_POL:   s = SEL_POL;
            WO_IE:    s = SEL_IE;
            WO_RAW:   s = SEL_RAW;
            WO_MIS:   s = SEL_MIS;
            WO_CLR:   s = SEL_CLR;
            WO_ALT:   s = SEL_ALT;
            default:  s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      if (STAGES < 2) $error("gpm_sync: STAGES must be at least 2");
      if (W < 1)      $error("gpm_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpm_irq.sv
module gpm_irq #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] sense,
   input  logic [W-1:0] both,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] clr,
   output logic [W-1:0] raw
);
   logic [W-1:0] prev;
   logic [W-1:0] hit;
   logic [W-1:0] raw_nxt;

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise = pin_s[i] & ~prev[i];
      assign fall = ~pin_s[i] & prev[i];
      assign hit[i] = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
      // level sense follows the pin; edge sense latches until cleared
      assign raw_nxt[i] = sense[i] ? ~(pin_s[i] ^ pol[i])
                                   : ((raw[i] & ~clr[i]) | hit[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         raw  <= '0;
      end else begin
         prev <= pin_s;
         raw  <= raw_nxt;
      end
   end
endmodule

// File: rtl/gpm_apb_gpio.sv
module gpm_apb_gpio #(
   parameter int PINS        = 8,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            pclk,
   input  logic            presetn,
   input  logic            psel,
   input  logic            penable,
   input  logic            pwrite,
   input  logic [11:0]     paddr,
   input  logic [DW-1:0]   pwdata,
   output logic [DW-1:0]   prdata,
   output logic            pready,
   output logic            pslverr,
   input  logic [PINS-1:0] pad_in,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_oe,
   input  logic [PINS-1:0] hw_out,
   input  logic [PINS-1:0] hw_oe,
   output logic            irq
);
   import gpm_pkg::*;

   localparam int MSB_MASK = PINS + 1;

   initial begin
      if (PINS < 1 || PINS > 8) $error("gpm_apb_gpio: PINS must be 1..8");
      if (DW < 8)               $error("gpm_apb_gpio: DW must be at least 8");
   end

   logic [PINS-1:0] dout_q, dir_q, sense_q, both_q, pol_q, ie_q, alt_q;
   logic [PINS-1:0] raw_q, pin_s, clr_pulse, amask, wbits, pin_val, rd_bits;
   gpm_sel_e        sel;
   logic            wr_en;
   logic            unused_bits;

   assign sel     = gpm_decode(paddr[11:2]);
   assign wr_en   = psel & penable & pwrite;
   assign amask   = paddr[MSB_MASK:2];
   assign wbits   = pwdata[PINS-1:0];
   assign unused_bits = ^{pwdata, paddr};

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         dout_q <= '0; dir_q <= '0; sense_q <= '0; both_q <= '0;
         pol_q  <= '0; ie_q  <= '0; alt_q   <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DATA:  dout_q  <= (dout_q & ~amask) | (wbits & amask);
            SEL_DIR:   dir_q   <= wbits;
            SEL_SENSE: sense_q <= wbits;
            SEL_BOTH:  both_q  <= wbits;
            SEL_POL:   pol_q   <= wbits;
            SEL_IE:    ie_q    <= wbits;
            SEL_ALT:   alt_q   <= wbits;
            default: ;
         endcase
      end
   end

   assign clr_pulse = (wr_en && sel == SEL_CLR) ? wbits : '0;

   gpm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(pclk), .rst_n(presetn), .din(pad_in), .dout(pin_s)
   );

   gpm_irq #(.W(PINS)) u_irq (
      .clk(pclk), .rst_n(presetn), .pin_s(pin_s), .sense(sense_q),
      .both(both_q), .pol(pol_q), .clr(clr_pulse), .raw(raw_q)
   );

   assign pin_val = (dir_q & dout_q) | (~dir_q & pin_s);

   always_comb begin
      case (sel)
         SEL_DATA:  rd_bits = pin_val & amask;
         SEL_DIR:   rd_bits = dir_q;
         SEL_SENSE: rd_bits = sense_q;
         SEL_BOTH:  rd_bits = both_q;
         SEL_POL:   rd_bits = pol_q;
         SEL_IE:    rd_bits = ie_q;
         SEL_RAW:   rd_bits = raw_q;
         SEL_MIS:   rd_bits = raw_q & ie_q;
         SEL_ALT:   rd_bits = alt_q;
         default:   rd_bits = '0;
      endcase
   end

   assign prdata  = {{(DW-PINS){1'b0}}, rd_bits};
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign irq     = |(raw_q & ie_q);

   for (genvar p = 0; p < PINS; p++) begin : g_pad
      assign pad_out[p] = alt_q[p] ? hw_out[p] : dout_q[p];
      assign pad_oe[p]  = alt_q[p] ? hw_oe[p]  : dir_q[p];
   end
endmodule

// File: rtl/gpm_chk.sv
module gpm_chk #(
   parameter int PINS = 8,
   parameter int DW   = 32
) (
   input logic            pclk,
   input logic            presetn,
   input logic            psel,
   input logic            penable,
   input logic            pwrite,
   input logic [11:0]     paddr,
   input logic [DW-1:0]   pwdata,
   input logic [DW-1:0]   prdata,
   input logic [PINS-1:0] pad_oe,
   input logic [PINS-1:0] dir_q,
   input logic [PINS-1:0] dout_q,
   input logic [PINS-1:0] alt_q,
   input logic [PINS-1:0] sense_q,
   input logic [PINS-1:0] raw_q,
   input logic [PINS-1:0] pin_s
);
   logic            acc_wr, in_data, is_clr, unmapped;
   logic [PINS-1:0] amask;

   assign acc_wr   = psel && penable && pwrite;
   assign in_data  = (paddr[11:10] == 2'b00);
   assign is_clr   = (paddr == 12'h41C);
   assign unmapped = !in_data && (paddr[11:2] > 10'h108);
   assign amask    = paddr[PINS+1:2];

   // R2
   masked_write_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc_wr && in_data) |=> (((dout_q ^ $past(dout_q)) & ~$past(amask)) == '0));

   // R2
   dout_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc_wr && in_data) |=> $stable(dout_q));

   // R4
   oe_dir_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (alt_q == '0) |-> (pad_oe == dir_q));

   // R6
   edge_latch_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc_wr && is_clr) |=>
         (($past(raw_q) & ~raw_q & ~sense_q & ~$past(sense_q)) == '0));

   // R9
   clear_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (acc_wr && is_clr && $stable(pin_s)) |=>
         ((raw_q & $past(pwdata[PINS-1:0] & ~sense_q)) == '0));

   // R11
   unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && unmapped) |-> (prdata == '0));
endmodule

bind gpm_apb_gpio gpm_chk #(.PINS(PINS), .DW(DW)) u_chk (
   .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
   .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
   .pad_oe(pad_oe), .dir_q(dir_q), .dout_q(dout_q), .alt_q(alt_q),
   .sense_q(sense_q), .raw_q(raw_q), .pin_s(pin_s)
);

// File: tb/gpm_apb_gpio_bench.sv
module gpm_apb_gpio_bench;
   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, irq;
   logic [7:0]  pad_in = '0, hw_out = '0, hw_oe = '0;
   logic [7:0]  pad_out, pad_oe;

   int total = 0;
   int bad   = 0;
   logic [7:0] m_dout = '0, m_dir = '0;

   always #10 pclk = ~pclk;

   gpm_apb_gpio u_gpm_apb_gpio (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .hw_out(hw_out), .hw_oe(hw_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge pclk); penable = 1;
      @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge pclk); penable = 1;
      #2 d = prdata;
      @(negedge pclk); psel = 0; penable = 0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge pclk);
   endtask

   initial begin
      #(20 * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      idle(3);
      presetn = 1;
      idle(1);

      // R1 reset state
      check("R1 pad_oe", {24'b0, pad_oe}, 0);
      check("R1 irq", {31'b0, irq}, 0);
      for (int a = 12'h400; a <= 12'h420; a += 4) rd_chk("R1 reg", a[11:0], 0);
      rd_chk("R1 data", 12'h3FC, 0);

      // R12 readback, R9 clear reads 0
      for (int a = 12'h400; a <= 12'h410; a += 4) begin
         wr(a[11:0], 32'h5A ^ a);
         rd_chk("R12 readback", a[11:0], {24'b0, 8'(32'h5A ^ a)});
         wr(a[11:0], 0);
      end
      wr(12'h420, 32'hC3);
      rd_chk("R12 alt readback", 12'h420, 32'hC3);
      wr(12'h420, 0);
      wr(12'h41C, 32'hFF);
      rd_chk("R9 clear reads 0", 12'h41C, 0);

      // R2 masked write sweep, R4 pad drive
      wr(12'h400, 32'hFF); m_dir = 8'hFF;
      for (int m = 0; m < 256; m++) begin
         logic [7:0] v;
         v = 8'((m * 37 + 5) & 255);
         wr({2'b00, m[7:0], 2'b00}, {24'hABCDEF, v});
         m_dout = (m_dout & ~m[7:0]) | (v & m[7:0]);
         rd_chk("R2 masked write", 12'h3FC, {24'b0, m_dout});
         check("R4 pad_out", {24'b0, pad_out}, {24'b0, m_dout});
      end
      check("R4 pad_oe", {24'b0, pad_oe}, 32'hFF);

      // R3 masked read sweep with mixed direction
      wr(12'h400, 32'h0F); m_dir = 8'h0F;
      check("R4 pad_oe mixed", {24'b0, pad_oe}, 32'h0F);
      for (int k = 0; k < 2; k++) begin
         pad_in = (k == 0) ? 8'h96 : 8'h3C;
         idle(4);
         for (int m = 0; m < 256; m++)
            rd_chk("R3 masked read", {2'b00, m[7:0], 2'b00},
                   {24'b0, ((m_dir & m_dout) | (~m_dir & pad_in)) & m[7:0]});
      end

      // R5 alternate function
      hw_out = 8'hF0; hw_oe = 8'hAA;
      wr(12'h420, 32'h33);
      check("R5 pad_out", {24'b0, pad_out}, {24'b0, (8'h33 & hw_out) | (8'hCC & m_dout)});
      check("R5 pad_oe", {24'b0, pad_oe}, {24'b0, (8'h33 & hw_oe) | (8'hCC & m_dir)});
      wr(12'h420, 0);

      // interrupts: inputs, clean start
      wr(12'h400, 0);
      pad_in = 8'h00; idle(5);
      wr(12'h41C, 32'hFF);
      rd_chk("R9 cleared", 12'h414, 0);

      // R6 single-edge polarity, R10 masking
      wr(12'h40C, 32'h0F);
      wr(12'h410, 32'h10);
      pad_in = 8'hFF; idle(5);
      rd_chk("R6 rising", 12'h414, 32'h0F);
      rd_chk("R10 masked", 12'h418, 0);
      check("R10 irq low", {31'b0, irq}, 0);
      pad_in = 8'h00; idle(5);
      rd_chk("R6 falling", 12'h414, 32'hFF);
      rd_chk("R10 masked set", 12'h418, 32'h10);
      check("R10 irq high", {31'b0, irq}, 1);
      wr(12'h41C, 32'hF0);
      rd_chk("R9 partial clear", 12'h414, 32'h0F);
      check("R10 irq after clear", {31'b0, irq}, 0);
      wr(12'h41C, 32'h0F);
      rd_chk("R9 full clear", 12'h414, 0);

      // R7 both edges
      wr(12'h408, 32'hFF); wr(12'h40C, 0);
      pad_in = 8'h01; idle(5);
      rd_chk("R7 rise", 12'h414, 32'h01);
      wr(12'h41C, 32'hFF);
      pad_in = 8'h00; idle(5);
      rd_chk("R7 fall", 12'h414, 32'h01);
      wr(12'h41C, 32'hFF);

      // R8 level sense
      wr(12'h408, 0); wr(12'h40C, 32'hF0); wr(12'h404, 32'hFF);
      idle(2);
      rd_chk("R8 level low", 12'h414, 32'h0F);
      pad_in = 8'hFF; idle(5);
      rd_chk("R8 level high", 12'h414, 32'hF0);
      wr(12'h41C, 32'hFF);
      rd_chk("R8 level ignores clear", 12'h414, 32'hF0);

      // R11 unmapped and response
      rd_chk("R11 0x424", 12'h424, 0);
      rd_chk("R11 0x800", 12'h800, 0);
      rd_chk("R11 0xFFC", 12'hFFC, 0);
      check("R11 pready", {31'b0, pready}, 1);
      check("R11 pslverr", {31'b0, pslverr}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule